// File: doc/BRIEF.md
# Complementary-Pair Key Lock on an Adder Carry

This block hides the correct behaviour of a small host function behind a secret key. The host here is an N-bit adder. Its carry-out is the protected wire. The adder's first operand is also copied into a lock network. That network builds two key-gated copies of the operand. One copy feeds an N-input AND. The other copy feeds the complement of that AND. The two results are ANDed into a single flip bit, and the flip bit is XORed onto the carry.

When the key makes both gated copies equal, the two functions are exact opposites. Their AND is then zero for every operand, and the adder works normally. When the key is wrong, the flip bit rises for exactly one operand value and inverts the carry there. Only one output combination is wrong per wrong key, so every key guess must be ruled out by its own query.

Each key gate is an XOR or an XNOR. A per-bit polarity parameter fixes which one. An optional hardened variant adds N more key bits. These bits act on internal nets of the second copy.

Top module: `cplock_adder`

## Requirements
- R1: `sum` equals the low N bits of `a + b + cin` for every operand and every key.
- R2: When the key is correct, `cout` equals the true carry of `a + b + cin` for all 2^N values of `a`. With OBF=0 the key is correct when `(ka ^ POL_A) == (kb ^ POL_B)`. With OBF=1 it is correct when `(ka ^ POL_A) == (kb ^ POL_B ^ ki)`.
- R3: When the key is wrong, `cout` is the inverted true carry for exactly one operand value. That value is `a == ~(ka ^ POL_A)`. For every other `a`, `cout` is the true carry.
- R4: The key is split into fields:
  - `ka` is `lock_key[N-1:0]` and gates the copy that feeds the AND.
  - `kb` is `lock_key[2N-1:N]` and gates the copy that feeds the complemented AND.
  - A polarity bit of 1 makes that gate an XNOR. A polarity bit of 0 makes it an XOR.
- R5: With OBF=1, the key is 3N bits wide and `ki = lock_key[3N-1:2N]`. Each bit of `ki` inverts one bit of the second copy after its key gate. This changes which keys count as correct but not the trigger operand.
- R6: The default parameters are N=8, POL_A=8'h3C and POL_B=8'h5A. With these, the all-zero key is wrong and corrupts the carry only at `a == 8'hC3`. The key `ka=8'h00`, `kb=8'h66` is correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First adder operand. It also feeds the lock network. |
| b | input | N | Second adder operand. |
| cin | input | 1 | Adder carry-in. |
| lock_key | input | 2N, or 3N when OBF=1 | Unlock key, split into the `ka`, `kb` and `ki` fields. |
| sum | output | N | Adder sum. The key never affects it. |
| cout | output | 1 | Protected carry-out: the true carry XOR the flip bit. |

## Verification
The hardest condition to reach from the ports is the corruption of a wrong key. It appears for a single operand out of 2^N, so random stimulus almost never finds it. The stimulus therefore sweeps every value of `a` under each key. It varies `b` and `cin` alongside, so the trigger lands on both carry values. The bench then counts how many carries differed from the true carry and compares that count with one for each wrong key and zero for each correct key. Two instances run side by side, the plain variant and the hardened one. Some keys are correct for one instance and wrong for the other, which exercises the internal-net key bits.

// File: rtl/cplock_adder.sv
module cplock_adder #(
  parameter int N = 8,
  parameter bit OBF = 1'b0,
  parameter logic [N-1:0] POL_A = N'('h3C),
  parameter logic [N-1:0] POL_B = N'('h5A),
  localparam int KW = OBF ? 3*N : 2*N
) (
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  b,
  input  logic          cin,
  input  logic [KW-1:0] lock_key,
  output logic [N-1:0]  sum,
  output logic          cout
);

  logic [N:0]   total;
  logic [N-1:0] k_a, k_b, k_int;
  logic [N-1:0] e_a, e_b;
  logic         g_hi, g_lo, flip;

  assign total = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
  assign sum   = total[N-1:0];

  assign k_a = lock_key[N-1:0];
  assign k_b = lock_key[2*N-1:N];

  generate
    if (OBF) begin : g_obf
      assign k_int = lock_key[KW-1:2*N];
    end else begin : g_base
      assign k_int = '0;
    end
  endgenerate

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (POL_A[i]) begin : g_xnor_a
        assign e_a[i] = ~(a[i] ^ k_a[i]);
      end else begin : g_xor_a
        assign e_a[i] = a[i] ^ k_a[i];
      end
      if (POL_B[i]) begin : g_xnor_b
        assign e_b[i] = ~(a[i] ^ k_b[i]) ^ k_int[i];
      end else begin : g_xor_b
        assign e_b[i] = (a[i] ^ k_b[i]) ^ k_int[i];
      end
    end
  endgenerate

  assign g_hi = &e_a;
  assign g_lo = ~(&e_b);
  assign flip = g_hi & g_lo;
  assign cout = total[N] ^ flip;

  logic key_ok, trig;
  assign key_ok = ((k_a ^ POL_A) == (k_b ^ POL_B ^ k_int));
  assign trig   = ((a ^ k_a ^ POL_A) == {N{1'b1}});

  always_comb begin
    if (!$isunknown({a, lock_key, flip})) begin
      AST_GOOD_KEY_NO_FLIP: assert (!(key_ok && flip));      // R2
      AST_FLIP_ONLY_AT_TRIG: assert (!flip || trig);          // R3
      AST_TRIG_BAD_KEY_FLIPS: assert (!(trig && !key_ok) || flip); // R3
      AST_FLIP_MEANS_BAD_KEY: assert (!flip || !key_ok);      // R5
    end
  end

endmodule

// File: tb/sim_cplock_adder.sv
module sim_cplock_adder;
  localparam int N = 8;
  localparam logic [N-1:0] PA = 8'h3C;
  localparam logic [N-1:0] PB = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [N-1:0]   a, b;
  logic           cin;
  logic [2*N-1:0] key0;
  logic [3*N-1:0] key1;
  logic [N-1:0]   s0, s1;
  logic           c0, c1;

  cplock_adder #(.N(N), .OBF(1'b0), .POL_A(PA), .POL_B(PB)) u0 (
    .a(a), .b(b), .cin(cin), .lock_key(key0), .sum(s0), .cout(c0));
  cplock_adder #(.N(N), .OBF(1'b1), .POL_A(PA), .POL_B(PB)) u1 (
    .a(a), .b(b), .cin(cin), .lock_key(key1), .sum(s1), .cout(c1));

  typedef struct {
    string        tag;
    logic [N-1:0] es;
    logic         ec0;
    logic         ec1;
    logic         tc;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int bad0 = 0;
  int bad1 = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(s0 == it.es && s1 == it.es, "R1", "sum", {s1, s0}, {it.es, it.es});
      chk(c0 == it.ec0, it.tag, "cout plain", c0, it.ec0);
      chk(c1 == it.ec1, it.tag, "cout hardened", c1, it.ec1);
      if (c0 != it.tc) bad0++;
      if (c1 != it.tc) bad1++;
    end
  end

  task automatic sweep(input string tag, input logic [N-1:0] k1,
                       input logic [N-1:0] k2, input logic [N-1:0] ki,
                       input int seed);
    bit wrong0, wrong1;
    wrong0 = ((k1 ^ PA) != (k2 ^ PB));
    wrong1 = ((k1 ^ PA) != (k2 ^ PB ^ ki));
    bad0 = 0;
    bad1 = 0;
    for (int v = 0; v < (1 << N); v++) begin
      item_t it;
      logic [N:0] t;
      bit trg;
      @(posedge clk);
      #1;
      a    = N'(v);
      b    = N'(v * 29 + seed);
      cin  = ((v >> 1) & 1) != 0;
      key0 = {k2, k1};
      key1 = {ki, k2, k1};
      t    = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
      trg  = ((a ^ k1 ^ PA) == {N{1'b1}});
      it.tag = tag;
      it.es  = t[N-1:0];
      it.tc  = t[N];
      it.ec0 = t[N] ^ (trg && wrong0);
      it.ec1 = t[N] ^ (trg && wrong1);
      q.push_back(it);
    end
    @(negedge clk);
    #1;
    chk(bad0 == (wrong0 ? 1 : 0), tag, "plain corrupt count", bad0, wrong0 ? 1 : 0);
    chk(bad1 == (wrong1 ? 1 : 0), tag, "hardened corrupt count", bad1, wrong1 ? 1 : 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    a = '0; b = '0; cin = 1'b0; key0 = '0; key1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s0 == 0 && c0 == 0 && s1 == 0 && c1 == 0, "R1", "reset outputs",
        {c1, s1, c0, s0}, 0);
    rst = 1'b0;
    sweep("R2_R4", 8'h00, 8'h66, 8'h00, 3);   // correct key for both
    sweep("R2", 8'hA7, 8'hC1, 8'h00, 17);      // another correct key
    sweep("R6", 8'h00, 8'h00, 8'h00, 91);      // zero key, trigger C3
    sweep("R3", 8'h00, 8'hE6, 8'h00, 5);       // single-bit mismatch
    sweep("R3", 8'h0F, 8'h96, 8'h00, 200);     // all bits mismatched
    sweep("R5", 8'h00, 8'h66, 8'h01, 44);      // hardened wrong only
    sweep("R5", 8'h00, 8'h67, 8'h01, 123);     // hardened correct only
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule